// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block runs the memory sequences a small 8-bit processor needs to enter and leave exception handlers. It handles reset, an edge-triggered non-maskable interrupt, a level-sensitive maskable interrupt and a software break. It also handles the return from a handler. It owns the address, read/write and write-data signals for the duration of a sequence. Return state is saved on a stack confined to page 1 of memory. The new program counter is fetched from a fixed two-byte vector near the top of the address space.

The core around it supplies the current program counter and status byte, and pulses a strobe for break or return. When `done_o` pulses, the core takes over `pc_o` and `stat_o`. The low byte of the stack pointer lives inside the block. Its page bit is always 1, and it is visible on `sp_o`. Instruction decode and arithmetic live elsewhere.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst` is high there are no reads, writes or vector pulls, and `sp_o` is 0x1FF. After release the block reads 0xFFFC and then 0xFFFD, with no stack writes. It then pulses `done_o` with `pc_o` = {byte at 0xFFFD, byte at 0xFFFC}.
- R2: A break strobe accepted while idle writes pc_i+2 to the stack, high byte first and then low byte. It then writes the status byte with bits 4 and 5 forced to 1, and reads the vector at 0xFFFE/0xFFFF. `done_o` is high in the 7th cycle after the cycle the strobe was sampled in, and low in the 6th.
- R3: A stack write first decrements the stack pointer and then writes to address {0x01, sp}. A stack read reads {0x01, sp} and then increments the pointer. The low byte wraps modulo 256, so every stack access stays in page 1.
- R4: A maskable request with status bit 2 clear enters with the unmodified pc_i. The stacked status has bit 4 = 0 and bit 5 = 1, and the vector is read from 0xFFFE/0xFFFF.
- R5: A maskable request while status bit 2 is set causes no bus activity, and `busy_o` stays low.
- R6: The non-maskable request reacts to a rising edge of `nmi_i` only, and its vector is at 0xFFFA/0xFFFB. A level held high causes no second entry. An edge seen while a sequence is running is served once that sequence has finished.
- R7: Requests sampled in the same idle cycle are served in this order: non-maskable, maskable, break, return. The losers among break and return are dropped.
- R8: `vpull_o` is high exactly in the two vector read cycles, always with `re_o` high.
- R9: On completion of any entry, `stat_o` equals `stat_i` as sampled at acceptance, with bit 2 = 1, bit 3 = 0, bit 4 = 0 and bit 5 = 1.
- R10: A return strobe reads the status byte, then the PC low byte, then the PC high byte from the stack. `pc_o` is the restored PC, and `stat_o` is the pulled byte with bit 4 = 0 and bit 5 = 1.
- R11: Break and return strobes that arrive while a sequence is running have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the reset sequence on release |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_i | input | 1 | Maskable request, level sensitive |
| brk_i | input | 1 | Break strobe from the decoder |
| rti_i | input | 1 | Return-from-handler strobe |
| pc_i | input | 16 | Current program counter |
| stat_i | input | 8 | Current status byte (bit 2 interrupt mask, bit 3 decimal) |
| rdata_i | input | 8 | Read data for the address on `addr_o` |
| addr_o | output | 16 | Memory address |
| we_o | output | 1 | Write cycle |
| re_o | output | 1 | Read cycle |
| wdata_o | output | 8 | Write data |
| vpull_o | output | 1 | Vector fetch indicator |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse: `pc_o`/`stat_o` are new |
| pc_o | output | 16 | Program counter produced by the sequence |
| stat_o | output | 8 | Status produced by the sequence |
| sp_o | output | 9 | Stack pointer, top bit always 1 |

## Verification
Entries are driven for each kind in turn: reset, a break, an unmasked request, a masked request, a non-maskable edge, and all four requests raised together. The stacked bytes tell apart the +2 break return address and the B bit, and the vector address tells apart the entry kind. Two returns unwind the frames in reverse order, which shows that push and pull use the stack pointer in matching ways. A non-maskable edge placed inside a running break separates a latched edge from a sampled level. A run of ninety breaks makes the pointer wrap inside page 1.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_RST, S_IDLE, S_DUMMY, S_PUSH_H, S_PUSH_L, S_PUSH_P,
    S_VEC_L, S_VEC_H, S_PULL_P, S_PULL_L, S_PULL_H, S_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    K_RESET, K_NMI, K_IRQ, K_BRK, K_RTI
  } seq_kind_t;

  // status bit positions
  localparam int ST_IMASK = 2;
  localparam int ST_DEC   = 3;
  localparam int ST_BRK   = 4;
  localparam int ST_ONE   = 5;

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
  import irq_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      nmi_i,
  input  logic      irq_i,
  input  logic      irq_masked,
  input  logic      brk_i,
  input  logic      rti_i,
  input  logic      accept,
  output logic      valid,
  output seq_kind_t kind
);

  localparam int NREQ = 4;

  logic            nmi_q;
  logic            pend_q;
  logic            nmi_edge;
  logic            nmi_req;
  logic [NREQ-1:0] req;
  logic [NREQ-1:0] gnt;

  assign nmi_edge = nmi_i & ~nmi_q;
  assign nmi_req  = pend_q | nmi_edge;
  // index order is priority order
  assign req      = {rti_i, brk_i, irq_i & ~irq_masked, nmi_req};

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign valid = accept & (|req);

  always_comb begin
    kind = K_RTI;
    if (gnt[0])      kind = K_NMI;
    else if (gnt[1]) kind = K_IRQ;
    else if (gnt[2]) kind = K_BRK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= nmi_req & ~(accept & gnt[0]);
    end
  end

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !accept) |=> pend_q); // R6

endmodule

// File: rtl/irq_seq_stack.sv
module irq_seq_stack #(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] PAGE   = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  push,
  input  logic                  pull,
  output logic [DATA_W-1:0]     sp,
  output logic [2*DATA_W-1:0]   dec_addr,
  output logic [2*DATA_W-1:0]   cur_addr,
  output logic [2*DATA_W-1:0]   inc_addr
);

  localparam logic [DATA_W-1:0] SP_ONE = DATA_W'(1);

  assign dec_addr = {PAGE, sp - SP_ONE};
  assign cur_addr = {PAGE, sp};
  assign inc_addr = {PAGE, sp + SP_ONE};

  always_ff @(posedge clk) begin
    if (rst)       sp <= '1;
    else if (push) sp <= sp - SP_ONE;
    else if (pull) sp <= sp + SP_ONE;
  end

  AST_SP_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    push |=> (sp == $past(sp) - SP_ONE)); // R3
  AST_SP_PULL_STEP: assert property (@(posedge clk) disable iff (rst)
    (pull && !push) |=> (sp == $past(sp) + SP_ONE)); // R3

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 16,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE,
  parameter int                BRK_STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_i,
  input  logic              irq_i,
  input  logic              brk_i,
  input  logic              rti_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic              re_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              vpull_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W:0]   sp_o
);

  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(BRK_STEP);
  localparam logic [ADDR_W-1:0] ONE_A   = ADDR_W'(1);

  seq_state_t        st_q, st_n;
  seq_kind_t         kind_q, arb_kind;
  logic              arb_valid, accept;
  logic              push, pull;
  logic [ADDR_W-1:0] addr_n, vec_base;
  logic              we_n, re_n, vp_n;
  logic [DATA_W-1:0] wd_n;
  logic [ADDR_W-1:0] ret_pc_q;
  logic [DATA_W-1:0] psh_st_q, new_st_q, lo_q;
  logic [DATA_W-1:0] sp;
  logic [ADDR_W-1:0] dec_addr, cur_addr, inc_addr;

  function automatic logic [DATA_W-1:0] entry_status(input logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] r;
    r = s;
    r[ST_ONE]   = 1'b1;
    r[ST_IMASK] = 1'b1;
    r[ST_DEC]   = 1'b0;
    r[ST_BRK]   = 1'b0;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] stacked_status(input logic [DATA_W-1:0] s,
                                                       input logic sw);
    logic [DATA_W-1:0] r;
    r = s;
    r[ST_ONE] = 1'b1;
    r[ST_BRK] = sw;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] restored_status(input logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] r;
    r = s;
    r[ST_ONE] = 1'b1;
    r[ST_BRK] = 1'b0;
    return r;
  endfunction

  assign accept = (st_q == S_IDLE);

  irq_seq_arb u_arb (
    .clk        (clk),
    .rst        (rst),
    .nmi_i      (nmi_i),
    .irq_i      (irq_i),
    .irq_masked (stat_i[ST_IMASK]),
    .brk_i      (brk_i),
    .rti_i      (rti_i),
    .accept     (accept),
    .valid      (arb_valid),
    .kind       (arb_kind)
  );

  irq_seq_stack #(
    .DATA_W (DATA_W),
    .PAGE   (STACK_PAGE)
  ) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pull     (pull),
    .sp       (sp),
    .dec_addr (dec_addr),
    .cur_addr (cur_addr),
    .inc_addr (inc_addr)
  );

  always_comb begin
    unique case (kind_q)
      K_RESET: vec_base = VEC_RST;
      K_NMI:   vec_base = VEC_NMI;
      default: vec_base = VEC_IRQ;
    endcase
  end

  // next state and the bus values of the next cycle
  always_comb begin
    st_n   = st_q;
    addr_n = '0;
    we_n   = 1'b0;
    re_n   = 1'b0;
    vp_n   = 1'b0;
    wd_n   = '0;
    push   = 1'b0;
    pull   = 1'b0;
    unique case (st_q)
      S_RST: begin
        st_n = S_VEC_L; addr_n = VEC_RST; re_n = 1'b1; vp_n = 1'b1;
      end
      S_IDLE: begin
        if (arb_valid) begin
          if (arb_kind == K_RTI) begin
            st_n = S_PULL_P; addr_n = cur_addr; re_n = 1'b1;
          end else begin
            st_n = S_DUMMY;
          end
        end
      end
      S_DUMMY: begin
        st_n = S_PUSH_H; push = 1'b1; addr_n = dec_addr; we_n = 1'b1;
        wd_n = ret_pc_q[ADDR_W-1:DATA_W];
      end
      S_PUSH_H: begin
        st_n = S_PUSH_L; push = 1'b1; addr_n = dec_addr; we_n = 1'b1;
        wd_n = ret_pc_q[DATA_W-1:0];
      end
      S_PUSH_L: begin
        st_n = S_PUSH_P; push = 1'b1; addr_n = dec_addr; we_n = 1'b1;
        wd_n = psh_st_q;
      end
      S_PUSH_P: begin
        st_n = S_VEC_L; addr_n = vec_base; re_n = 1'b1; vp_n = 1'b1;
      end
      S_VEC_L: begin
        st_n = S_VEC_H; addr_n = vec_base + ONE_A; re_n = 1'b1; vp_n = 1'b1;
      end
      S_VEC_H:  st_n = S_DONE;
      S_PULL_P: begin
        st_n = S_PULL_L; pull = 1'b1; addr_n = inc_addr; re_n = 1'b1;
      end
      S_PULL_L: begin
        st_n = S_PULL_H; pull = 1'b1; addr_n = inc_addr; re_n = 1'b1;
      end
      S_PULL_H: begin
        st_n = S_DONE; pull = 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_RST;
      kind_q   <= K_RESET;
      addr_o   <= '0;
      we_o     <= 1'b0;
      re_o     <= 1'b0;
      vpull_o  <= 1'b0;
      wdata_o  <= '0;
      done_o   <= 1'b0;
      pc_o     <= '0;
      stat_o   <= '0;
      ret_pc_q <= '0;
      psh_st_q <= '0;
      new_st_q <= '0;
      lo_q     <= '0;
    end else begin
      st_q    <= st_n;
      addr_o  <= addr_n;
      we_o    <= we_n;
      re_o    <= re_n;
      vpull_o <= vp_n;
      wdata_o <= wd_n;
      done_o  <= 1'b0;
      unique case (st_q)
        S_RST: new_st_q <= entry_status(stat_i);
        S_IDLE: begin
          if (arb_valid) begin
            kind_q   <= arb_kind;
            ret_pc_q <= (arb_kind == K_BRK) ? pc_i + PC_STEP : pc_i;
            psh_st_q <= stacked_status(stat_i, arb_kind == K_BRK);
            new_st_q <= entry_status(stat_i);
          end
        end
        S_VEC_L, S_PULL_L: lo_q <= rdata_i;
        S_PULL_P: psh_st_q <= rdata_i;
        S_VEC_H: begin
          pc_o   <= {rdata_i, lo_q};
          stat_o <= new_st_q;
          done_o <= 1'b1;
        end
        S_PULL_H: begin
          pc_o   <= {rdata_i, lo_q};
          stat_o <= restored_status(psh_st_q);
          done_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign sp_o   = {1'b1, sp};

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!we_o && !re_o && !vpull_o && sp_o == {1'b1, {DATA_W{1'b1}}})); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R2
  AST_WE_STACK_PAGE: assert property (@(posedge clk) disable iff (rst)
    we_o |-> (addr_o[ADDR_W-1:DATA_W] == STACK_PAGE)); // R3
  AST_VP_VECTOR: assert property (@(posedge clk) disable iff (rst)
    vpull_o |-> (re_o && !we_o && addr_o >= VEC_NMI)); // R8

endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_i = 1'b0, irq_i = 1'b0, brk_i = 1'b0, rti_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  stat_i = '0;
  logic [7:0]  rdata_i;
  logic [15:0] addr_o, pc_o;
  logic        we_o, re_o, vpull_o, busy_o, done_o;
  logic [7:0]  wdata_o, stat_o;
  logic [8:0]  sp_o;

  always #4 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst(rst), .nmi_i(nmi_i), .irq_i(irq_i), .brk_i(brk_i),
    .rti_i(rti_i), .pc_i(pc_i), .stat_i(stat_i), .rdata_i(rdata_i),
    .addr_o(addr_o), .we_o(we_o), .re_o(re_o), .wdata_o(wdata_o),
    .vpull_o(vpull_o), .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o),
    .stat_o(stat_o), .sp_o(sp_o)
  );

  typedef struct {
    bit          is_res;
    logic [15:0] addr;
    logic        we;
    logic [7:0]  wd;
    logic        vp;
    logic [15:0] pc;
    logic [7:0]  st;
    string       req;
  } item_t;

  item_t       q[$];
  item_t       mon_it;
  int          n_cmp = 0, n_bad = 0;
  bit          finished = 0;
  logic [7:0]  stk[0:255];
  logic [7:0]  exp_stk[0:255];
  logic [7:0]  exp_sp = 8'hFF;
  logic [15:0] v_nmi = 16'h8A01, v_rst = 16'h4C20, v_irq = 16'h7F3E;

  always @(posedge clk) if (we_o && addr_o[15:8] == 8'h01) stk[addr_o[7:0]] <= wdata_o;

  always_comb begin
    case (addr_o)
      16'hFFFA: rdata_i = v_nmi[7:0];
      16'hFFFB: rdata_i = v_nmi[15:8];
      16'hFFFC: rdata_i = v_rst[7:0];
      16'hFFFD: rdata_i = v_rst[15:8];
      16'hFFFE: rdata_i = v_irq[7:0];
      16'hFFFF: rdata_i = v_irq[15:8];
      default:  rdata_i = (addr_o[15:8] == 8'h01) ? stk[addr_o[7:0]] : 8'hEE;
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expectations as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (vpull_o && !re_o) chk(0, "R8", "vector pull outside read", 1, 0);
      if (we_o || re_o) begin
        if (q.size() == 0 || q[0].is_res) chk(0, "R11", "unexpected bus cycle", addr_o, 0);
        else begin
          mon_it = q.pop_front();
          chk(addr_o == mon_it.addr, mon_it.req, "address", addr_o, mon_it.addr);
          chk(we_o == mon_it.we, mon_it.req, "write flag", we_o, mon_it.we);
          chk(vpull_o == mon_it.vp, "R8", "vector pull", vpull_o, mon_it.vp);
          if (mon_it.we) chk(wdata_o == mon_it.wd, mon_it.req, "write data", wdata_o, mon_it.wd);
        end
      end
      if (done_o) begin
        if (q.size() == 0 || !q[0].is_res) chk(0, "R11", "unexpected completion", pc_o, 0);
        else begin
          mon_it = q.pop_front();
          chk(pc_o == mon_it.pc, mon_it.req, "new pc", pc_o, mon_it.pc);
          chk(stat_o == mon_it.st, mon_it.req, "new status", stat_o, mon_it.st);
        end
      end
    end
  end

  function automatic void exp_bus(input logic [15:0] a, input logic w, input logic [7:0] d,
                                  input logic v, input string r);
    item_t it;
    it.is_res = 0; it.addr = a; it.we = w; it.wd = d; it.vp = v;
    it.pc = '0; it.st = '0; it.req = r;
    q.push_back(it);
  endfunction

  function automatic void exp_res(input logic [15:0] p, input logic [7:0] s, input string r);
    item_t it;
    it.is_res = 1; it.addr = '0; it.we = 0; it.wd = '0; it.vp = 0;
    it.pc = p; it.st = s; it.req = r;
    q.push_back(it);
  endfunction

  function automatic void exp_push(input logic [7:0] d, input string r);
    exp_sp = exp_sp - 8'd1;
    exp_stk[exp_sp] = d;
    exp_bus({8'h01, exp_sp}, 1'b1, d, 1'b0, r);
  endfunction

  function automatic logic [7:0] exp_pull(input string r);
    logic [7:0] d;
    d = exp_stk[exp_sp];
    exp_bus({8'h01, exp_sp}, 1'b0, 8'h00, 1'b0, r);
    exp_sp = exp_sp + 8'd1;
    return d;
  endfunction

  function automatic logic [7:0] entry_st(input logic [7:0] s);
    return (s | 8'h24) & ~8'h18;
  endfunction

  function automatic void exp_entry(input logic [15:0] ret, input logic [7:0] s, input bit sw,
                                    input logic [15:0] vec, input logic [15:0] vval,
                                    input string r);
    exp_push(ret[15:8], r);
    exp_push(ret[7:0], r);
    exp_push(sw ? (s | 8'h30) : ((s | 8'h20) & ~8'h10), r);
    exp_bus(vec, 1'b0, 8'h00, 1'b1, "R8");
    exp_bus(vec + 16'd1, 1'b0, 8'h00, 1'b1, "R8");
    exp_res(vval, entry_st(s), "R9");
  endfunction

  function automatic void exp_rti();
    logic [7:0] s, l, h;
    s = exp_pull("R10");
    l = exp_pull("R10");
    h = exp_pull("R10");
    exp_res({h, l}, (s | 8'h20) & ~8'h10, "R10");
  endfunction

  task automatic wait_done(input string r);
    bit seen;
    seen = 0;
    for (int k = 0; k < 60 && !seen; k++) begin
      @(negedge clk);
      if (done_o) begin
        seen = 1;
        pc_i = pc_o;
        stat_i = stat_o;
      end
    end
    chk(seen, r, "completion seen", seen, 1);
  endtask

  task automatic do_brk(input string r);
    exp_entry(pc_i + 16'd2, stat_i, 1'b1, 16'hFFFE, v_irq, r);
    @(negedge clk) brk_i = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 1) brk_i = 1'b0;
      if (k >= 6) chk(done_o == (k == 7), "R2", "done timing", done_o, k == 7);
    end
    pc_i = pc_o;
    stat_i = stat_o;
  endtask

  task automatic do_rti();
    exp_rti();
    @(negedge clk) rti_i = 1'b1;
    @(negedge clk) rti_i = 1'b0;
    wait_done("R10");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset
    stat_i = 8'hCB;
    repeat (3) begin
      @(negedge clk);
      chk(!we_o && !re_o && !vpull_o, "R1", "quiet in reset", {we_o, re_o, vpull_o}, 0);
      chk(sp_o == 9'h1FF, "R1", "sp in reset", sp_o, 9'h1FF);
    end
    exp_bus(16'hFFFC, 1'b0, 8'h00, 1'b1, "R1");
    exp_bus(16'hFFFD, 1'b0, 8'h00, 1'b1, "R1");
    exp_res(v_rst, entry_st(8'hCB), "R1");
    rst = 1'b0;
    wait_done("R1");
    repeat (3) @(negedge clk);
    chk(sp_o == 9'h1FF, "R1", "no stack writes", sp_o, 9'h1FF);

    // R2: break
    pc_i = 16'h1234; stat_i = 8'hE3;
    do_brk("R2");
    repeat (2) @(negedge clk);

    // R5: masked request ignored
    stat_i = 8'h04; irq_i = 1'b1;
    repeat (10) begin
      @(negedge clk);
      chk(!busy_o, "R5", "busy while masked", busy_o, 0);
    end
    irq_i = 1'b0;

    // R4: unmasked request
    pc_i = 16'hABCD; stat_i = 8'h81;
    exp_entry(16'hABCD, 8'h81, 1'b0, 16'hFFFE, v_irq, "R4");
    irq_i = 1'b1;
    wait_done("R4");
    irq_i = 1'b0;
    repeat (4) @(negedge clk);

    // R10: unwind both frames
    do_rti();
    do_rti();
    repeat (2) @(negedge clk);
    chk(sp_o == 9'h1FF, "R3", "sp after unwinding", sp_o, 9'h1FF);

    // R7: all requests together
    pc_i = 16'h2468; stat_i = 8'h40;
    exp_entry(16'h2468, 8'h40, 1'b0, 16'hFFFA, v_nmi, "R7");
    @(negedge clk);
    nmi_i = 1'b1; irq_i = 1'b1; brk_i = 1'b1; rti_i = 1'b1;
    @(negedge clk);
    brk_i = 1'b0; rti_i = 1'b0;
    wait_done("R7");
    irq_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy_o, "R6", "held level no re-entry", busy_o, 0);

    // R6 / R11: edge during a running break, break strobe while busy
    nmi_i = 1'b0;
    repeat (2) @(negedge clk);
    pc_i = 16'h3000; stat_i = 8'h02;
    exp_entry(16'h3002, 8'h02, 1'b1, 16'hFFFE, v_irq, "R6");
    exp_entry(v_irq, entry_st(8'h02), 1'b0, 16'hFFFA, v_nmi, "R6");
    @(negedge clk) brk_i = 1'b1;
    @(negedge clk) brk_i = 1'b0;
    @(negedge clk) nmi_i = 1'b1;
    @(negedge clk) brk_i = 1'b1;
    @(negedge clk) brk_i = 1'b0;
    wait_done("R6");
    wait_done("R6");
    repeat (4) @(negedge clk);

    // R3: wrap of the stack pointer inside page 1
    pc_i = 16'h5555; stat_i = 8'h00;
    for (int i = 0; i < 90; i++) do_brk("R3");
    @(negedge clk);
    chk(sp_o == {1'b1, exp_sp}, "R3", "sp after wrap", sp_o, {1'b1, exp_sp});
    do_rti();

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R11", "pending expectations", q.size(), 0);
    finished = 1;
    summary();
    $finish;
  end

endmodule